// File: doc/BRIEF.md
# SMM Protected Memory Decoder

This block sits in the request path of a host memory controller and decides, for every memory request, whether the request reaches DRAM or goes to a discard sink. It guards three protected windows. The first is a segment at the top of low memory: its base is the top-of-low-memory input minus a size chosen by an encoded field. The second is the 128 KiB legacy window at 0xA0000. The third is a 128 KiB high alias at 0xFEDA0000, which maps onto the same storage as the legacy window.

Only a CPU running in system-management mode may reach the protected storage. Accesses by a CPU outside that mode are discarded, and so are all bus-master DMA accesses. A discarded read returns all-ones and a discarded write is dropped. One control register holds the window enables, the size code and a lock bit. Once the lock bit is set, the register cannot change again before reset.

Each accepted request gives one registered result one clock later. That result is either a DRAM-forward strobe carrying the address, data and byte enables, or a sink acknowledge carrying the read data.

Top module: `smm_prot_decode`

## Requirements
- R1: Control bit 0 enables the top segment. Control bits [2:1] select its size: 00 = 1 MiB, 01 = 2 MiB, 10 = 8 MiB, 11 = reserved, which gives size zero and no segment. With bit 0 clear the segment is absent whatever the size code.
- R2: The segment covers addresses from `tolm` minus the size up to `tolm - 1` inclusive. An address at `tolm`, or just below the base, is outside the segment and is forwarded.
- R3: A CPU read outside SMM that hits a protected window asserts `sink_ack` for one cycle with `sink_rdata` = 0xFFFFFFFF, and does not assert `dram_req`.
- R4: A write that is discarded asserts `sink_ack` with `sink_rdata` = 0 and produces no DRAM strobe.
- R5: A DMA request (`req_dma` = 1) that hits any protected window is discarded even when `req_smm` is also 1.
- R6: A CPU request in SMM to the top segment or the legacy window is forwarded with its address unchanged. Its write flag, write data and byte enables are passed through as well.
- R7: Control bit 4 enables the legacy window 0x000A0000 to 0x000BFFFF, which then follows the same protection rules. With bit 4 clear, those addresses are forwarded.
- R8: Control bit 3 enables the high window 0xFEDA0000 to 0xFEDBFFFF. With the window enabled, an SMM CPU access is forwarded to 0x000A0000 plus its offset within the window, and all other accesses are discarded. With bit 3 clear, these addresses are forwarded unchanged.
- R9: Control bit 5 is a lock. Once it is set, every later control write, including one that tries to clear the lock, is ignored until reset.
- R10: A request sampled on the same clock edge as a control write is decoded with the old control value. Requests sampled on later edges use the new value.
- R11: After reset the control register is zero, so every window is disabled, and neither strobe is asserted.
- R12: Each request sampled with `req_valid` = 1 gives exactly one of `dram_req` or `sink_ack` in the following cycle. A cycle with no request gives neither.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control value: [0] segment enable, [2:1] size code, [3] high window enable, [4] legacy window enable, [5] lock |
| tolm | input | ADDR_W | Top of low memory, 1 MiB aligned and at least 8 MiB |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Requester is in system-management mode |
| req_dma | input | 1 | Requester is a bus-master DMA engine |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, 1 to 4 bytes |
| dram_req | output | 1 | Forward strobe to DRAM |
| dram_addr | output | ADDR_W | Forwarded address, remapped for high-window hits |
| dram_write | output | 1 | Forwarded write flag |
| dram_wdata | output | DATA_W | Forwarded write data |
| dram_be | output | DATA_W/8 | Forwarded byte enables |
| sink_ack | output | 1 | Request was discarded |
| sink_rdata | output | DATA_W | All-ones for a discarded read, zero otherwise |

## Verification
The hardest case to reach from the ports is a request that arrives on the exact edge where the control register changes. The decode must use the value from before the write, and that difference is invisible unless both happen in the same cycle. The stimulus reaches this case by driving a control write and a request in one cycle while the segment goes from disabled to enabled. It expects a forward on that edge and a discard on the next one. A second hard case is the lock: it can only be seen through later decodes. After locking, the bench tries to disable the windows and to clear the lock, then shows that the protected addresses are still discarded.

// File: rtl/smm_pkg.sv
package smm_pkg;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_DRAM = 2'd1,
      ROUTE_SINK = 2'd2
   } route_e;

   // control register bit positions
   localparam int CTL_W        = 6;
   localparam int CTL_SEG_EN   = 0;
   localparam int CTL_SZ_LO    = 1;
   localparam int CTL_HIGH_EN  = 3;
   localparam int CTL_LEG_EN   = 4;
   localparam int CTL_LOCK     = 5;

   // segment size in bytes; zero means no segment
   function automatic logic [31:0] seg_bytes(input logic en, input logic [1:0] code);
      logic [31:0] sz;
      unique case (code)
         2'b00:   sz = 32'h0010_0000;
         2'b01:   sz = 32'h0020_0000;
         2'b10:   sz = 32'h0080_0000;
         default: sz = 32'h0000_0000;
      endcase
      return en ? sz : 32'h0;
   endfunction

endpackage

// File: rtl/smm_ctl_reg.sv
module smm_ctl_reg
   import smm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             seg_en,
   output logic [1:0]       seg_code,
   output logic             high_en,
   output logic             leg_en
);

   logic [CTL_W-1:0] ctl_q;
   logic             locked;

   assign locked = ctl_q[CTL_LOCK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_wr && !locked)
         ctl_q <= ctl_wdata;
   end

   assign seg_en   = ctl_q[CTL_SEG_EN];
   assign seg_code = ctl_q[CTL_SZ_LO +: 2];
   assign high_en  = ctl_q[CTL_HIGH_EN];
   assign leg_en   = ctl_q[CTL_LEG_EN];

   // R9
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(ctl_q));

endmodule

// File: rtl/smm_win_dec.sv
module smm_win_dec #(
   parameter int          ADDR_W    = 32,
   parameter logic [31:0] LEG_BASE  = 32'h000A_0000,
   parameter logic [31:0] HIGH_BASE = 32'hFEDA_0000,
   parameter logic [31:0] WIN_BYTES = 32'h0002_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] tolm,
   input  logic              seg_en,
   input  logic [1:0]        seg_code,
   input  logic              leg_en,
   input  logic              high_en,
   output logic              seg_hit,
   output logic              leg_hit,
   output logic              high_hit,
   output logic [ADDR_W-1:0] alias_addr
);
   import smm_pkg::*;

   localparam logic [ADDR_W-1:0] LEG_LO  = ADDR_W'(LEG_BASE);
   localparam logic [ADDR_W-1:0] LEG_HI  = ADDR_W'(LEG_BASE) + ADDR_W'(WIN_BYTES);
   localparam logic [ADDR_W-1:0] HIGH_LO = ADDR_W'(HIGH_BASE);
   localparam logic [ADDR_W-1:0] HIGH_HI = ADDR_W'(HIGH_BASE) + ADDR_W'(WIN_BYTES);

   logic [ADDR_W-1:0] seg_sz;
   logic [ADDR_W-1:0] seg_base;

   assign seg_sz   = ADDR_W'(seg_bytes(seg_en, seg_code));
   assign seg_base = tolm - seg_sz;

   assign seg_hit  = (seg_sz != '0) && (addr >= seg_base) && (addr < tolm);
   assign leg_hit  = leg_en  && (addr >= LEG_LO)  && (addr < LEG_HI);
   assign high_hit = high_en && (addr >= HIGH_LO) && (addr < HIGH_HI);

   assign alias_addr = LEG_LO + (addr - HIGH_LO);

endmodule

// File: rtl/smm_prot_decode.sv
module smm_prot_decode #(
   parameter int          ADDR_W    = 32,
   parameter int          DATA_W    = 32,
   parameter logic [31:0] LEG_BASE  = 32'h000A_0000,
   parameter logic [31:0] HIGH_BASE = 32'hFEDA_0000,
   parameter logic [31:0] WIN_BYTES = 32'h0002_0000,
   localparam int         BE_W      = DATA_W / 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ctl_wr,
   input  logic [smm_pkg::CTL_W-1:0] ctl_wdata,
   input  logic [ADDR_W-1:0]         tolm,
   input  logic                      req_valid,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic                      req_write,
   input  logic                      req_smm,
   input  logic                      req_dma,
   input  logic [DATA_W-1:0]         req_wdata,
   input  logic [BE_W-1:0]           req_be,
   output logic                      dram_req,
   output logic [ADDR_W-1:0]         dram_addr,
   output logic                      dram_write,
   output logic [DATA_W-1:0]         dram_wdata,
   output logic [BE_W-1:0]           dram_be,
   output logic                      sink_ack,
   output logic [DATA_W-1:0]         sink_rdata
);
   import smm_pkg::*;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 32) begin : g_bad_addr
         $error("ADDR_W must reach the high alias window");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("sink works on 4-byte units, DATA_W must be 32");
      end
      if ((WIN_BYTES & (WIN_BYTES - 32'd1)) != 32'd0) begin : g_bad_win
         $error("WIN_BYTES must be a power of two");
      end
   endgenerate

   logic              seg_en, high_en, leg_en;
   logic [1:0]        seg_code;
   logic              seg_hit, leg_hit, high_hit;
   logic [ADDR_W-1:0] alias_addr;
   logic              prot_hit;
   logic              trusted;
   route_e            route_n;

   smm_ctl_reg u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .seg_en    (seg_en),
      .seg_code  (seg_code),
      .high_en   (high_en),
      .leg_en    (leg_en)
   );

   smm_win_dec #(
      .ADDR_W    (ADDR_W),
      .LEG_BASE  (LEG_BASE),
      .HIGH_BASE (HIGH_BASE),
      .WIN_BYTES (WIN_BYTES)
   ) u_dec (
      .addr       (req_addr),
      .tolm       (tolm),
      .seg_en     (seg_en),
      .seg_code   (seg_code),
      .leg_en     (leg_en),
      .high_en    (high_en),
      .seg_hit    (seg_hit),
      .leg_hit    (leg_hit),
      .high_hit   (high_hit),
      .alias_addr (alias_addr)
   );

   assign prot_hit = seg_hit | leg_hit | high_hit;
   // DMA never counts as SMM
   assign trusted  = req_smm & ~req_dma;

   always_comb begin
      if (!req_valid)
         route_n = ROUTE_NONE;
      else if (prot_hit && !trusted)
         route_n = ROUTE_SINK;
      else
         route_n = ROUTE_DRAM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dram_req   <= 1'b0;
         dram_addr  <= '0;
         dram_write <= 1'b0;
         dram_wdata <= '0;
         dram_be    <= '0;
         sink_ack   <= 1'b0;
         sink_rdata <= '0;
      end else begin
         dram_req   <= (route_n == ROUTE_DRAM);
         sink_ack   <= (route_n == ROUTE_SINK);
         sink_rdata <= (route_n == ROUTE_SINK && !req_write) ? '1 : '0;
         if (route_n == ROUTE_DRAM) begin
            dram_addr  <= high_hit ? alias_addr : req_addr;
            dram_write <= req_write;
            dram_wdata <= req_wdata;
            dram_be    <= req_be;
         end
      end
   end

   // R12
   strobe_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dram_req && sink_ack));

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dram_req && !sink_ack));

   // R3
   sink_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_smm && seg_hit) |=> (sink_ack && sink_rdata == '1));

   // R4
   drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_dma && prot_hit) |=> (sink_ack && sink_rdata == '0));

   // R5
   dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dma && prot_hit) |=> !dram_req);

   // R8
   high_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && high_hit && req_smm && !req_dma) |=>
         (dram_req && dram_addr >= ADDR_W'(LEG_BASE)
                   && dram_addr <  ADDR_W'(LEG_BASE) + ADDR_W'(WIN_BYTES)));

endmodule

// File: tb/smm_prot_decode_test.sv
module smm_prot_decode_test;

   localparam int CLK_PERIOD = 10;
   localparam int RT_NONE = 0;
   localparam int RT_DRAM = 1;
   localparam int RT_SINK = 2;

   typedef struct packed {
      logic [31:0] addr;
      logic        we;
      logic        smm;
      logic        dma;
      logic [1:0]  route;
      logic [31:0] xaddr;
   } vec_t;

   // control = 0x1B: segment on, 2 MiB, high and legacy windows on; tolm = 0x80000000
   localparam vec_t VECS [14] = '{
      '{32'h7FE0_0000, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0},           // R3 segment base
      '{32'h7FFF_FFFC, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0},           // R4 segment top word
      '{32'h7FE0_0000, 1'b0, 1'b1, 1'b0, 2'd1, 32'h7FE0_0000},   // R6
      '{32'h7FF0_0000, 1'b0, 1'b1, 1'b1, 2'd2, 32'h0},           // R5
      '{32'h7FDF_FFFC, 1'b0, 1'b0, 1'b0, 2'd1, 32'h7FDF_FFFC},   // R2 below base
      '{32'h8000_0000, 1'b0, 1'b0, 1'b0, 2'd1, 32'h8000_0000},   // R2 at tolm
      '{32'h000A_0000, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0},           // R7
      '{32'h000B_FFFC, 1'b0, 1'b1, 1'b0, 2'd1, 32'h000B_FFFC},   // R7
      '{32'h000C_0000, 1'b0, 1'b0, 1'b0, 2'd1, 32'h000C_0000},   // R7 past end
      '{32'hFEDA_0010, 1'b0, 1'b1, 1'b0, 2'd1, 32'h000A_0010},   // R8 remap
      '{32'hFEDA_0010, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0},           // R8
      '{32'hFEDB_FFFC, 1'b1, 1'b1, 1'b0, 2'd1, 32'h000B_FFFC},   // R8
      '{32'hFEDC_0000, 1'b0, 1'b0, 1'b0, 2'd1, 32'hFEDC_0000},   // R8 past end
      '{32'h7FE0_0000, 1'b1, 1'b1, 1'b1, 2'd2, 32'h0}            // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [5:0]  ctl_wdata = '0;
   logic [31:0] tolm = 32'h8000_0000;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_smm = 1'b0;
   logic        req_dma = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        dram_req;
   logic [31:0] dram_addr;
   logic        dram_write;
   logic [31:0] dram_wdata;
   logic [3:0]  dram_be;
   logic        sink_ack;
   logic [31:0] sink_rdata;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smm_prot_decode uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .tolm       (tolm),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_smm    (req_smm),
      .req_dma    (req_dma),
      .req_wdata  (req_wdata),
      .req_be     (req_be),
      .dram_req   (dram_req),
      .dram_addr  (dram_addr),
      .dram_write (dram_write),
      .dram_wdata (dram_wdata),
      .dram_be    (dram_be),
      .sink_ack   (sink_ack),
      .sink_rdata (sink_rdata)
   );

   task automatic write_ctl(input logic [5:0] v);
      @(negedge clk);
      req_valid = 1'b0;
      ctl_wr    = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr    = 1'b0;
   endtask

   // drive at negedge, sampled at posedge, outputs read 1 time unit later
   task automatic issue(input logic [31:0] a, input logic we, input logic smm,
                        input logic dma, input logic [3:0] be);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_write = we;
      req_smm   = smm;
      req_dma   = dma;
      req_be    = be;
      req_wdata = a ^ 32'h5A5A_5A5A;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input string tag, input int route, input logic [31:0] xaddr);
      logic ok;
      n_vec++;
      case (route)
         RT_DRAM: ok = dram_req && !sink_ack && dram_addr == xaddr && dram_write == req_write
                       && dram_be == req_be && dram_wdata == req_wdata;
         RT_SINK: ok = sink_ack && !dram_req
                       && sink_rdata == (req_write ? 32'h0 : 32'hFFFF_FFFF);
         default: ok = !dram_req && !sink_ack;
      endcase
      if (!ok) begin
         n_bad++;
         $display("FAIL %s addr=%h: got dram_req=%b sink_ack=%b dram_addr=%h rdata=%h be=%b, expected route=%0d addr=%h",
                  tag, req_addr, dram_req, sink_ack, dram_addr, sink_rdata, dram_be, route, xaddr);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      expect_out("R11", RT_NONE, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R11 everything disabled after reset, all forwarded unchanged
      issue(32'h7FE0_0000, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R11", RT_DRAM, 32'h7FE0_0000);
      issue(32'h000A_0000, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R7",  RT_DRAM, 32'h000A_0000);
      issue(32'hFEDA_0010, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R8",  RT_DRAM, 32'hFEDA_0010);

      // R10 write and request on the same edge: old decode, then new
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = 6'h03;
      req_valid = 1'b1; req_addr = 32'h7FF0_0000; req_write = 1'b0;
      req_smm = 1'b0; req_dma = 1'b0; req_be = 4'hF; req_wdata = req_addr ^ 32'h5A5A_5A5A;
      @(posedge clk); #1;
      expect_out("R10", RT_DRAM, 32'h7FF0_0000);
      @(negedge clk);
      ctl_wr = 1'b0;
      @(posedge clk); #1;
      expect_out("R10", RT_SINK, 32'h0);

      // R1 / R2 size codes
      write_ctl(6'h01);
      issue(32'h7FF0_0000, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R1", RT_SINK, 32'h0);
      issue(32'h7FEF_FFFC, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R2", RT_DRAM, 32'h7FEF_FFFC);
      write_ctl(6'h05);
      issue(32'h7F80_0000, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R1", RT_SINK, 32'h0);
      issue(32'h7F7F_FFFC, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R2", RT_DRAM, 32'h7F7F_FFFC);
      write_ctl(6'h07);
      issue(32'h7FFF_FFFC, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R1", RT_DRAM, 32'h7FFF_FFFC);
      write_ctl(6'h04);
      issue(32'h7FFF_FFFC, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R1", RT_DRAM, 32'h7FFF_FFFC);

      // vector table with all windows on
      write_ctl(6'h1B);
      for (int i = 0; i < 14; i++) begin
         issue(VECS[i].addr, VECS[i].we, VECS[i].smm, VECS[i].dma, 4'hF);
         expect_out($sformatf("R3-table[%0d]", i), int'(VECS[i].route), VECS[i].xaddr);
      end

      // R6 partial byte enables pass through
      issue(32'h7FE0_0004, 1'b1, 1'b1, 1'b0, 4'b0010);
      expect_out("R6", RT_DRAM, 32'h7FE0_0004);
      // R3 single-byte read is still all-ones
      issue(32'h7FE0_0005, 1'b0, 1'b0, 1'b0, 4'b0010);
      expect_out("R3", RT_SINK, 32'h0);

      // R12 idle cycle gives no strobe
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #1;
      expect_out("R12", RT_NONE, 32'h0);

      // R9 lock, then attempts to disable and to unlock
      write_ctl(6'h33);
      write_ctl(6'h00);
      issue(32'h7FF0_0000, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R9", RT_SINK, 32'h0);
      issue(32'h000A_0100, 1'b1, 1'b0, 1'b0, 4'hF);  expect_out("R9", RT_SINK, 32'h0);
      write_ctl(6'h1B);
      issue(32'hFEDA_0000, 1'b0, 1'b0, 1'b0, 4'hF);  expect_out("R9", RT_DRAM, 32'hFEDA_0000);

      @(negedge clk);
      req_valid = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule